// File: doc/BRIEF.md
# Elementary-Interval Gray Range Encoder

This block turns a raw range-field value taken from a packet header into a short identifier code, which is then used as the search key for that field in a ternary match array. The value space of the field is cut into elementary intervals. The cut points are the endpoints of every rule range, plus one default range that spans the whole space. Each interval has an identifier drawn from a binary reflected Gray sequence. Every interval that no rule range covers shares one common default identifier. Because of this, a rule range usually reduces to a few ternary strings over the identifier, and not to many prefixes over the raw value.

Software computes the interval lower bounds and their codes offline. It loads them as rows of an ascending table and then sets how many rows are live. On each lookup, all live rows are compared with the field value in parallel. The last row whose lower bound is at or below the value holds the containing interval, and the code of that row is returned one cycle later with a valid strobe. A value below every live bound, or a lookup while no row is live, returns the default code given by a parameter.

Top module: `range_gray_encoder`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` is 0 and `outCode` equals the `DEF_CODE` parameter. The live-row count resets to 0.
- R2: A lookup presented with `keyValid` high at a rising edge gives `outValid` high for exactly the following cycle. Without a new lookup, `outValid` returns to 0.
- R3: The result code is the code of the highest-indexed live row whose lower bound is less than or equal to the key. A key equal to a bound belongs to that bound's interval.
- R4: A key below the lower bound of every live row returns `DEF_CODE`.
- R5: While the live-row count is 0, every key returns `DEF_CODE`.
- R6: Rows at an index equal to or above the live-row count have no effect on the result, whatever their bounds and codes.
- R7: A row write (`cfgRowWe`, with `cfgIdx` selecting row 0 to DEPTH-1) takes effect for lookups presented in later cycles.
- R8: `outCode` keeps its value in every cycle in which no lookup is captured.
- R9: A lookup presented in the same cycle as a row write is resolved against the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cfgRowWe | input | 1 | Write strobe for one table row |
| cfgIdx | input | IDX_W | Row index for the write |
| cfgBound | input | FIELD_W | Lower bound of the interval written to the row |
| cfgCode | input | CODE_W | Identifier code written to the row |
| cfgCntWe | input | 1 | Write strobe for the live-row count |
| cfgCnt | input | CNT_W | New live-row count, saturated at DEPTH |
| keyValid | input | 1 | Lookup strobe |
| keyValue | input | FIELD_W | Field value to encode |
| outValid | output | 1 | Result strobe, one cycle after the lookup |
| outCode | output | CODE_W | Interval identifier code |

## Verification
The bench builds the block with a 5-bit field, a 4-bit code and nine rows. With these values it can walk the full nine-interval example table and probe both edges of every interval. It sets `DEF_CODE` to 1111 rather than 0000. This keeps the default result apart from intervals that are programmed with code 0000, so that R4 and R5 can be observed at the output. A second, shorter table then leaves stale rows above the live count, so their bounds and codes could capture a key if the count were not honoured.

// File: rtl/range_gray_encoder_pkg.sv
package range_gray_encoder_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic rowWe;    // row write, index already range-checked
    logic cntWe;    // live-row count write
    logic capture;  // register the lookup result
  } ctlStrobes_t;

endpackage

// File: rtl/range_gray_encoder_ctl.sv
module range_gray_encoder_ctl
  import range_gray_encoder_pkg::*;
#(
  parameter int DEPTH = 9,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgRowWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             cfgCntWe,
  input  logic             keyValid,
  output ctlStrobes_t      strobes,
  output logic             outValid
);

  localparam int IDX_SPAN = 1 << IDX_W;

  logic idxInRange;

  generate
    if (IDX_SPAN > DEPTH) begin : g_idxCheck
      assign idxInRange = (int'(cfgIdx) < DEPTH);
    end else begin : g_idxFull
      assign idxInRange = 1'b1;
    end
  endgenerate

  always_comb begin
    strobes.rowWe   = cfgRowWe && idxInRange;
    strobes.cntWe   = cfgCntWe;
    strobes.capture = keyValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= keyValid;
  end

  AST_ROW_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rowWe |-> (int'(cfgIdx) < DEPTH)); // R7

endmodule

// File: rtl/range_gray_encoder_dp.sv
module range_gray_encoder_dp
  import range_gray_encoder_pkg::*;
#(
  parameter int             FIELD_W  = 5,
  parameter int             CODE_W   = 4,
  parameter int             DEPTH    = 9,
  parameter int             IDX_W    = 4,
  parameter int             CNT_W    = 4,
  parameter logic [CODE_W-1:0] DEF_CODE = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [FIELD_W-1:0] cfgBound,
  input  logic [CODE_W-1:0]  cfgCode,
  input  logic [CNT_W-1:0]   cfgCnt,
  input  logic [FIELD_W-1:0] keyValue,
  output logic [CODE_W-1:0]  outCode
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);

  logic [FIELD_W-1:0] boundTab [DEPTH];
  logic [CODE_W-1:0]  codeTab  [DEPTH];
  logic [CNT_W-1:0]   liveCnt;
  logic [DEPTH-1:0]   rowHit;
  logic [CODE_W-1:0]  selCode;

  // per-row storage and parallel compare
  generate
    for (genvar r = 0; r < DEPTH; r++) begin : g_row
      always_ff @(posedge clk) begin
        if (!rstN) begin
          boundTab[r] <= '0;
          codeTab[r]  <= '0;
        end else if (strobes.rowWe && (int'(cfgIdx) == r)) begin
          boundTab[r] <= cfgBound;
          codeTab[r]  <= cfgCode;
        end
      end
      assign rowHit[r] = (CNT_W'(r) < liveCnt) && (boundTab[r] <= keyValue);
    end
  endgenerate

  // highest live row at or below the key wins
  always_comb begin
    selCode = DEF_CODE;
    for (int r = 0; r < DEPTH; r++) begin
      if (rowHit[r]) selCode = codeTab[r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveCnt <= '0;
      outCode <= DEF_CODE;
    end else begin
      if (strobes.cntWe) liveCnt <= (cfgCnt > MAX_CNT) ? MAX_CNT : cfgCnt;
      if (strobes.capture) outCode <= selCode;
    end
  end

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    liveCnt <= MAX_CNT); // R6
  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(outCode)); // R8
  AST_EMPTY_GIVES_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && liveCnt == '0) |=> (outCode == DEF_CODE)); // R5

endmodule

// File: rtl/range_gray_encoder.sv
module range_gray_encoder
  import range_gray_encoder_pkg::*;
#(
  parameter int                FIELD_W  = 5,
  parameter int                CODE_W   = 4,
  parameter int                DEPTH    = 9,
  parameter logic [CODE_W-1:0] DEF_CODE = '0,
  localparam int               IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int               CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgRowWe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [FIELD_W-1:0] cfgBound,
  input  logic [CODE_W-1:0]  cfgCode,
  input  logic               cfgCntWe,
  input  logic [CNT_W-1:0]   cfgCnt,
  input  logic               keyValid,
  input  logic [FIELD_W-1:0] keyValue,
  output logic               outValid,
  output logic [CODE_W-1:0]  outCode
);

  ctlStrobes_t strobes;

  range_gray_encoder_ctl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_ctl (
    .clk(clk), .rstN(rstN), .cfgRowWe(cfgRowWe), .cfgIdx(cfgIdx),
    .cfgCntWe(cfgCntWe), .keyValid(keyValid), .strobes(strobes),
    .outValid(outValid)
  );

  range_gray_encoder_dp #(
    .FIELD_W(FIELD_W), .CODE_W(CODE_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
    .CNT_W(CNT_W), .DEF_CODE(DEF_CODE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgIdx(cfgIdx),
    .cfgBound(cfgBound), .cfgCode(cfgCode), .cfgCnt(cfgCnt),
    .keyValue(keyValue), .outCode(outCode)
  );

  AST_VALID_AFTER_KEY: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> outValid); // R2
  AST_NO_VALID_WITHOUT_KEY: assert property (@(posedge clk) disable iff (!rstN)
    !keyValid |=> !outValid); // R2

endmodule

// File: tb/test_range_gray_encoder.sv
module test_range_gray_encoder;

  localparam int          FIELD_W = 5;
  localparam int          CODE_W  = 4;
  localparam int          DEPTH   = 9;
  localparam logic [3:0]  DEFC    = 4'b1111;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgRowWe, cfgCntWe, keyValid;
  logic [3:0] cfgIdx;
  logic [4:0] cfgBound, keyValue;
  logic [3:0] cfgCode, cfgCnt;
  logic       outValid;
  logic [3:0] outCode;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  range_gray_encoder #(.FIELD_W(FIELD_W), .CODE_W(CODE_W), .DEPTH(DEPTH),
                       .DEF_CODE(DEFC)) i_range_gray_encoder (
    .clk(clk), .rstN(rstN), .cfgRowWe(cfgRowWe), .cfgIdx(cfgIdx),
    .cfgBound(cfgBound), .cfgCode(cfgCode), .cfgCntWe(cfgCntWe),
    .cfgCnt(cfgCnt), .keyValid(keyValid), .keyValue(keyValue),
    .outValid(outValid), .outCode(outCode)
  );

  // example table: lower bounds and Gray codes
  localparam logic [4:0] EX_BOUND [9] = '{5'd0, 5'd2, 5'd7, 5'd9, 5'd11,
                                          5'd14, 5'd23, 5'd28, 5'd30};
  localparam logic [3:0] EX_CODE  [9] = '{4'b0000, 4'b0001, 4'b0000, 4'b0010,
                                          4'b0110, 4'b0111, 4'b0101, 4'b0100,
                                          4'b0000};
  // {key, expected code} covering both edges of every interval
  localparam int NVEC = 18;
  localparam logic [8:0] VEC [NVEC] = '{
    {5'd0, 4'b0000}, {5'd1, 4'b0000}, {5'd2, 4'b0001}, {5'd6, 4'b0001},
    {5'd7, 4'b0000}, {5'd8, 4'b0000}, {5'd9, 4'b0010}, {5'd10, 4'b0010},
    {5'd11, 4'b0110}, {5'd13, 4'b0110}, {5'd14, 4'b0111}, {5'd22, 4'b0111},
    {5'd23, 4'b0101}, {5'd27, 4'b0101}, {5'd28, 4'b0100}, {5'd29, 4'b0100},
    {5'd30, 4'b0000}, {5'd31, 4'b0000}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeRow(input int idx, input logic [4:0] b, input logic [3:0] c);
    cfgRowWe = 1'b1; cfgIdx = 4'(idx); cfgBound = b; cfgCode = c;
    @(negedge clk);
    cfgRowWe = 1'b0;
  endtask

  task automatic writeCnt(input logic [3:0] n);
    cfgCntWe = 1'b1; cfgCnt = n;
    @(negedge clk);
    cfgCntWe = 1'b0;
  endtask

  // present key at a negedge, result visible at the next negedge
  task automatic lookup(input logic [4:0] v, input logic [3:0] exp, input string req);
    keyValid = 1'b1; keyValue = v;
    @(negedge clk);
    keyValid = 1'b0;
    check(outValid === 1'b1, "R2", int'(outValid), 1);
    check(outCode === exp, req, int'(outCode), int'(exp));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgRowWe = 1'b0; cfgCntWe = 1'b0; keyValid = 1'b0;
    cfgIdx = '0; cfgBound = '0; cfgCode = '0; cfgCnt = '0; keyValue = '0;
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R1", int'(outValid), 0);
    check(outCode === DEFC, "R1", int'(outCode), int'(DEFC));
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R1", int'(outValid), 0);

    // R5: empty table, rows still hold reset contents
    lookup(5'd12, DEFC, "R5");
    lookup(5'd0, DEFC, "R5");

    // program example table
    for (int i = 0; i < DEPTH; i++) writeRow(i, EX_BOUND[i], EX_CODE[i]);
    writeCnt(4'd9);

    // R3: table walk
    for (int i = 0; i < NVEC; i++) lookup(VEC[i][8:4], VEC[i][3:0], "R3");

    // R2: valid drops, R8: code holds while idle
    @(negedge clk);
    check(outValid === 1'b0, "R2", int'(outValid), 0);
    check(outCode === 4'b0000, "R8", int'(outCode), 0);
    repeat (3) @(negedge clk);
    check(outCode === 4'b0000, "R8", int'(outCode), 0);

    // R9: same-cycle write of row 5 not seen by the lookup
    cfgRowWe = 1'b1; cfgIdx = 4'd5; cfgBound = 5'd14; cfgCode = 4'b0011;
    keyValid = 1'b1; keyValue = 5'd14;
    @(negedge clk);
    cfgRowWe = 1'b0; keyValid = 1'b0;
    check(outCode === 4'b0111, "R9", int'(outCode), 7);
    // R7: visible on the following lookup
    lookup(5'd14, 4'b0011, "R7");
    lookup(5'd22, 4'b0011, "R7");

    // shorter table: two live rows, stale rows 2..8 above the count
    writeRow(0, 5'd10, 4'b0011);
    writeRow(1, 5'd20, 4'b1010);
    writeCnt(4'd2);
    lookup(5'd3, DEFC, "R4");
    lookup(5'd9, DEFC, "R4");
    lookup(5'd10, 4'b0011, "R3");
    lookup(5'd19, 4'b0011, "R3");
    lookup(5'd20, 4'b1010, "R3");
    lookup(5'd29, 4'b1010, "R6");
    lookup(5'd31, 4'b1010, "R6");

    // R5: count back to zero
    writeCnt(4'd0);
    lookup(5'd25, DEFC, "R5");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule